// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Handshake Lines

This block is a full-duplex asynchronous serial port. Its transmit and receive paths run on their own serial lines at the same time. On the chip side, the transmit path takes bytes from a valid/ready stream. The receive path hands bytes out through a one-entry holding register with its own valid/ready pair. Both directions use a frame of one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity.

A single configuration write sets two things: a 16-bit baud divisor and a flow-control enable. The divisor sets a 16x oversampling tick, so one bit lasts 16*(div+1) system clocks. With flow control on, two handshake lines come into play. An active-low clear-to-send input decides whether a new outgoing character may begin. An active-low request-to-send output tells the remote end whether the holding register has room for another byte. The receiver finds a start bit by oversampling and confirms it at its mid-point, then samples each later bit at its centre. If the stop bit is sampled low, the receiver drops the byte and raises a one-cycle error strobe.

Top module: `uart_fc`

## Requirements
- R1: After reset, uartTx is high, txReady is high, rxValid is low, rxFrameErr is low and rtsN is low. The reset divisor is 0 and flow control starts disabled.
- R2: A cycle with cfgWe high loads cfgDiv and cfgFlowEn. After that, each transmitted bit lasts 16*(div+1) clocks. The first bit of a character may be up to div clocks shorter, because the tick runs free.
- R3: The transmitter accepts a byte on a clock edge where txValid and txReady are both high. uartTx goes low on that same edge to begin the start bit. The eight data bits follow, least significant bit first, and then a high stop bit.
- R4: txReady is low from acceptance until the stop bit has run its full length. While txReady is high, uartTx is high.
- R5: With flow control enabled, ctsN high (deasserted) keeps txReady low, so no new character starts. If ctsN rises while a character is being sent, that character still completes correctly.
- R6: With flow control enabled, rtsN is low while the holding register is empty and high while it is full. With flow control disabled, rtsN stays low and ctsN has no effect on txReady.
- R7: A correctly framed character on uartRx fills the holding register. rxValid then goes high, and rxData holds the byte and stays stable until a cycle where rxValid and rxReady are both high empties the register.
- R8: A low pulse on uartRx shorter than half a bit time is ignored. It produces neither rxValid nor rxFrameErr.
- R9: When a stop bit is sampled low, rxFrameErr pulses high for exactly one cycle and the byte is not delivered.
- R10: Transmission and reception proceed at the same time without affecting each other.
- R11: A character that completes while the holding register is already full is discarded, and the byte already held is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgDiv | input | 16 | Baud divisor loaded on cfgWe |
| cfgFlowEn | input | 1 | Flow-control enable loaded on cfgWe |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmitter can accept a byte |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Holding register is full |
| rxReady | input | 1 | Consumer takes the held byte |
| rxFrameErr | output | 1 | One-cycle strobe on a bad stop bit |
| uartTx | output | 1 | Serial transmit line |
| uartRx | input | 1 | Serial receive line |
| ctsN | input | 1 | Clear to send, active low |
| rtsN | output | 1 | Request to send, active low |

## Verification
The bench raises ctsN midway through a character and checks that the character still completes. A design that aborted the character would show up as a corrupted byte, and one that ignored the line would start the next byte early. The bench also measures the start-bit length after two divisor writes, which catches an off-by-one in the tick period. It sends a sub-half-bit glitch, which a receiver without mid-point confirmation would decode as a spurious byte. It sends a low stop bit: a design that delivered the byte anyway, or stretched the error strobe, would fail there. Finally, it sends a second byte while the holding register is full, which exposes a design that overwrites the byte already held.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic txLoad;     // capture txData into the frame shifter
    logic txShift;    // advance the frame shifter by one bit
    logic rxShift;    // shift the centre sample into the receive register
    logic rxCapture;  // good stop bit: move byte into holding register
    logic rxFrameErr; // bad stop bit
  } strobe_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

endpackage

// File: rtl/uart_fc_baud.sv
module uart_fc_baud #(
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgDiv,
  output logic             tick
);
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_W'(DIV_RST);
      cnt    <= '0;
    end else if (cfgWe) begin
      divReg <= cfgDiv;
      cnt    <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_fc_ctrl.sv
module uart_fc_ctrl
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    flowEn,
  input  logic    txValid,
  input  logic    ctsAsserted,
  input  logic    rxLine,
  output logic    txReady,
  output strobe_t strb
);
  localparam int TW    = $clog2(OVS);
  localparam int FRAME = DATA_W + 2;
  localparam int BW    = $clog2(FRAME + 1);
  localparam int RBW   = $clog2(DATA_W);
  localparam logic [TW-1:0]  TLAST      = TW'(OVS - 1);
  localparam logic [TW-1:0]  START_LAST = TW'(OVS / 2 - 2);
  localparam logic [BW-1:0]  TX_LAST    = BW'(FRAME - 1);
  localparam logic [RBW-1:0] RX_LAST    = RBW'(DATA_W - 1);

  // ---------------- transmit sequencing ----------------
  logic          txBusy;
  logic [TW-1:0] txTick;
  logic [BW-1:0] txBit;

  assign txReady = !txBusy && (!flowEn || ctsAsserted);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txTick <= '0;
      txBit  <= '0;
    end else if (strb.txLoad) begin
      txBusy <= 1'b1;
      txTick <= '0;
      txBit  <= '0;
    end else if (txBusy && tick) begin
      txTick <= (txTick == TLAST) ? '0 : txTick + 1'b1;
      if (txTick == TLAST) begin
        txBit <= txBit + 1'b1;
        if (txBit == TX_LAST) txBusy <= 1'b0;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  rx_state_t      rxState;
  logic [TW-1:0]  rxTick;
  logic [RBW-1:0] rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBit   <= '0;
    end else if (tick) begin
      unique case (rxState)
        RX_IDLE: begin
          if (!rxLine) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (rxLine) begin
            rxState <= RX_IDLE;          // too short: glitch
          end else if (rxTick == START_LAST) begin
            rxState <= RX_DATA;          // mid-point of start bit reached
            rxTick  <= '0;
            rxBit   <= '0;
          end else begin
            rxTick <= rxTick + 1'b1;
          end
        end
        RX_DATA: begin
          rxTick <= (rxTick == TLAST) ? '0 : rxTick + 1'b1;
          if (rxTick == TLAST) begin
            rxBit <= rxBit + 1'b1;
            if (rxBit == RX_LAST) rxState <= RX_STOP;
          end
        end
        RX_STOP: begin
          rxTick <= (rxTick == TLAST) ? '0 : rxTick + 1'b1;
          if (rxTick == TLAST) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- strobes ----------------
  logic rxCentre;
  assign rxCentre = tick && (rxTick == TLAST);

  always_comb begin
    strb            = '0;
    strb.txLoad     = txValid && txReady;
    strb.txShift    = txBusy && tick && (txTick == TLAST);
    strb.rxShift    = (rxState == RX_DATA) && rxCentre;
    strb.rxCapture  = (rxState == RX_STOP) && rxCentre && rxLine;
    strb.rxFrameErr = (rxState == RX_STOP) && rxCentre && !rxLine;
  end
endmodule

// File: rtl/uart_fc_dpath.sv
module uart_fc_dpath
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              flowEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxReady,
  input  logic              uartRx,
  input  logic              ctsN,
  output logic              uartTx,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rtsN,
  output logic              rxLine,
  output logic              ctsAsserted
);
  localparam int FRAME = DATA_W + 2;
  localparam int SYNC  = 2;

  // two-stage synchronisers, reset to the idle/deasserted level
  logic [SYNC-1:0] rxSync;
  logic [SYNC-1:0] ctsSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync  <= '1;
      ctsSync <= '1;
    end else begin
      rxSync  <= {rxSync[SYNC-2:0], uartRx};
      ctsSync <= {ctsSync[SYNC-2:0], ctsN};
    end
  end

  assign rxLine      = rxSync[SYNC-1];
  assign ctsAsserted = !ctsSync[SYNC-1];

  // transmit frame shifter: stop, data, start (LSB leaves first)
  logic [FRAME-1:0] txShreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShreg <= '1;
    else if (strb.txLoad)  txShreg <= {1'b1, txData, 1'b0};
    else if (strb.txShift) txShreg <= {1'b1, txShreg[FRAME-1:1]};
  end

  assign uartTx = txShreg[0];

  // receive shifter and single holding register
  logic [DATA_W-1:0] rxShreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShreg <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strb.rxShift) rxShreg <= {rxLine, rxShreg[DATA_W-1:1]};
      if (strb.rxCapture && !rxValid) begin
        rxData  <= rxShreg;
        rxValid <= 1'b1;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  assign rtsN = flowEn & rxValid;
endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 16,
  parameter int OVS     = 16,
  parameter int DIV_RST = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              cfgFlowEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              rxFrameErr,
  output logic              uartTx,
  input  logic              uartRx,
  input  logic              ctsN,
  output logic              rtsN
);
  logic    flowEn;
  logic    tick;
  logic    rxLine;
  logic    ctsAsserted;
  strobe_t strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      flowEn <= 1'b0;
    else if (cfgWe) flowEn <= cfgFlowEn;
  end

  uart_fc_baud #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_baud (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDiv(cfgDiv), .tick(tick)
  );

  uart_fc_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .flowEn(flowEn),
    .txValid(txValid), .ctsAsserted(ctsAsserted), .rxLine(rxLine),
    .txReady(txReady), .strb(strb)
  );

  uart_fc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .flowEn(flowEn),
    .txData(txData), .rxReady(rxReady), .uartRx(uartRx), .ctsN(ctsN),
    .uartTx(uartTx), .rxData(rxData), .rxValid(rxValid), .rtsN(rtsN),
    .rxLine(rxLine), .ctsAsserted(ctsAsserted)
  );

  assign rxFrameErr = strb.rxFrameErr;
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              flowEn,
  input logic              txValid,
  input logic              txReady,
  input logic              uartTx,
  input logic              ctsN,
  input logic              rxValid,
  input logic              rxReady,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFrameErr,
  input logic              rtsN
);
  // R3: an accepted byte begins its start bit at once
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !uartTx);

  // R4: no second acceptance directly after one
  a_r4_busy_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R4: line idles high whenever a byte could be accepted
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> uartTx);

  // R5: deasserted clear-to-send (seen through the synchroniser) blocks new bytes
  a_r5_cts_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && $past(ctsN) && $past(ctsN, 2)) |-> !txReady);

  // R6: request-to-send held asserted without flow control
  a_r6_rts_off: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |-> !rtsN);

  // R7: held byte stays put until taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R9: framing error is a single-cycle strobe
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |=> !rxFrameErr);

  // R9: a bad frame never fills the holding register
  a_r9_no_deliver: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |=> !$rose(rxValid));
endmodule

bind uart_fc uart_fc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .flowEn(flowEn), .txValid(txValid),
  .txReady(txReady), .uartTx(uartTx), .ctsN(ctsN), .rxValid(rxValid),
  .rxReady(rxReady), .rxData(rxData), .rxFrameErr(rxFrameErr), .rtsN(rtsN)
);

// File: tb/uart_fc_tb.sv
module uart_fc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgDiv = '0;
  logic        cfgFlowEn = 1'b0;
  logic [7:0]  txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady = 1'b0;
  logic        rxFrameErr;
  logic        uartTx;
  logic        uartRx = 1'b1;
  logic        ctsN = 1'b1;
  logic        rtsN;

  int checkCnt = 0;
  int failCnt  = 0;
  int feCount  = 0;
  int bitClks  = 16;
  bit flowModel = 1'b0;
  bit done = 1'b0;
  bit prevFe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fc u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDiv(cfgDiv), .cfgFlowEn(cfgFlowEn),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .rxFrameErr(rxFrameErr),
    .uartTx(uartTx), .uartRx(uartRx), .ctsN(ctsN), .rtsN(rtsN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock model comparison, sampled just after each edge
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      if (rxFrameErr) feCount++;
      chk(!(prevFe && rxFrameErr), "R9 strobe length", 2, 1);
      prevFe = rxFrameErr;
      if (flowModel) chk(rtsN == rxValid, "R6 rts follows holding", int'(rtsN), int'(rxValid));
      else           chk(rtsN == 1'b0, "R6 rts held low", int'(rtsN), 0);
    end
  end

  task automatic cfgWrite(input logic [15:0] d, input bit f);
    @(negedge clk);
    cfgDiv = d; cfgFlowEn = f; cfgWe = 1'b1;
    @(posedge clk);
    flowModel = f;
    bitClks = 16 * (int'(d) + 1);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendTx(input logic [7:0] b);
    @(negedge clk);
    txData = b; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    chk(uartTx == 1'b0, "R3 start bit after accept", int'(uartTx), 0);
    chk(txReady == 1'b0, "R4 busy after accept", int'(txReady), 0);
  endtask

  task automatic captureTx(output logic [7:0] b, output bit stopOk);
    @(negedge uartTx);
    repeat (bitClks / 2) @(negedge clk);
    chk(uartTx == 1'b0, "R3 start bit centre", int'(uartTx), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bitClks) @(negedge clk);
      b[i] = uartTx;
    end
    repeat (bitClks) @(negedge clk);
    stopOk = uartTx;
  endtask

  task automatic sendRx(input logic [7:0] b, input bit stopBit);
    @(negedge clk);
    uartRx = 1'b0;
    repeat (bitClks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uartRx = b[i];
      repeat (bitClks) @(negedge clk);
    end
    uartRx = stopBit;
    repeat (stopBit ? bitClks : (bitClks * 3) / 4) @(negedge clk);
    uartRx = 1'b1;
  endtask

  task automatic measureStart(output int n);
    @(negedge uartTx);
    n = 0;
    forever begin
      @(negedge clk);
      if (uartTx) break;
      n++;
    end
  endtask

  task automatic popRx();
    @(negedge clk); rxReady = 1'b1;
    @(negedge clk); rxReady = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    bit         sOk;
    int         n;
    int         feBefore;

    repeat (5) @(negedge clk);
    chk(uartTx == 1'b1, "R1 tx idle", int'(uartTx), 1);
    chk(txReady == 1'b1, "R1 txReady", int'(txReady), 1);
    chk(rxValid == 1'b0, "R1 rxValid", int'(rxValid), 0);
    chk(rxFrameErr == 1'b0, "R1 frame err", int'(rxFrameErr), 0);
    chk(rtsN == 1'b0, "R1 rts", int'(rtsN), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2: bit length for two divisor values (first data bit is 1)
    cfgWrite(16'd3, 1'b0);
    fork
      sendTx(8'h01);
      measureStart(n);
    join
    chk(n >= 61 && n <= 64, "R2 start bit length div=3", n, 64);
    repeat (11 * bitClks) @(negedge clk);
    cfgWrite(16'd1, 1'b0);
    fork
      sendTx(8'h01);
      measureStart(n);
    join
    chk(n >= 31 && n <= 32, "R2 start bit length div=1", n, 32);
    repeat (11 * bitClks) @(negedge clk);

    // R3/R4: frame contents
    cfgWrite(16'd3, 1'b0);
    fork
      sendTx(8'hA5);
      captureTx(got, sOk);
    join
    chk(got == 8'hA5, "R3 tx byte", int'(got), 'hA5);
    chk(sOk, "R3 stop bit high", int'(sOk), 1);
    repeat (bitClks) @(negedge clk);
    chk(txReady == 1'b1, "R4 ready after stop", int'(txReady), 1);

    // R5: flow control on transmit
    cfgWrite(16'd3, 1'b1);
    ctsN = 1'b1;
    @(negedge clk);
    fork
      begin
        txData = 8'h96; txValid = 1'b1;
        repeat (200) @(negedge clk);
        chk(txReady == 1'b0, "R5 held while cts high", int'(txReady), 0);
        chk(uartTx == 1'b1, "R5 no start while cts high", int'(uartTx), 1);
        ctsN = 1'b0;
        while (!txReady) @(negedge clk);
        @(negedge clk);
        txValid = 1'b0;
      end
      captureTx(got, sOk);
      begin
        @(negedge uartTx);
        repeat (3 * bitClks) @(negedge clk);
        ctsN = 1'b1;
      end
    join
    chk(got == 8'h96 && sOk, "R5 char completes after cts drop", int'(got), 'h96);
    fork
      sendTx(8'h3E);
      begin
        repeat (200) @(negedge clk);
        chk(txReady == 1'b0 && uartTx == 1'b1, "R5 next char held", int'(txReady), 0);
        ctsN = 1'b0;
      end
      captureTx(got, sOk);
    join
    chk(got == 8'h3E, "R5 byte after release", int'(got), 'h3E);
    repeat (2 * bitClks) @(negedge clk);

    // R6/R7: receive with flow control on
    chk(rtsN == 1'b0, "R6 rts asserted when empty", int'(rtsN), 0);
    sendRx(8'h3C, 1'b1);
    chk(rxValid == 1'b1, "R7 byte delivered", int'(rxValid), 1);
    chk(rxData == 8'h3C, "R7 rx byte", int'(rxData), 'h3C);
    chk(rtsN == 1'b1, "R6 rts deasserted when full", int'(rtsN), 1);
    repeat (20) @(negedge clk);
    chk(rxValid == 1'b1 && rxData == 8'h3C, "R7 held until taken", int'(rxData), 'h3C);
    popRx();
    chk(rxValid == 1'b0, "R7 popped", int'(rxValid), 0);
    chk(rtsN == 1'b0, "R6 rts back asserted", int'(rtsN), 0);

    // R6: flow off ignores cts; R11 drop when full
    cfgWrite(16'd3, 1'b0);
    ctsN = 1'b1;
    repeat (4) @(negedge clk);
    chk(txReady == 1'b1, "R6 cts ignored", int'(txReady), 1);
    sendRx(8'hA1, 1'b1);
    chk(rxValid == 1'b1 && rtsN == 1'b0, "R6 rts low while full", int'(rtsN), 0);
    sendRx(8'h77, 1'b1);
    chk(rxData == 8'hA1, "R11 held byte kept", int'(rxData), 'hA1);
    popRx();
    chk(rxValid == 1'b0, "R11 second byte dropped", int'(rxValid), 0);
    ctsN = 1'b0;

    // R8: glitch shorter than half a bit
    feBefore = feCount;
    @(negedge clk); uartRx = 1'b0;
    repeat (20) @(negedge clk); uartRx = 1'b1;
    repeat (12 * bitClks) @(negedge clk);
    chk(rxValid == 1'b0, "R8 glitch gives no byte", int'(rxValid), 0);
    chk(feCount == feBefore, "R8 glitch gives no error", feCount - feBefore, 0);

    // R9: low stop bit
    feBefore = feCount;
    sendRx(8'h55, 1'b0);
    repeat (2 * bitClks) @(negedge clk);
    chk(feCount - feBefore == 1, "R9 one error strobe", feCount - feBefore, 1);
    chk(rxValid == 1'b0, "R9 byte dropped", int'(rxValid), 0);

    // R10: full duplex
    fork
      sendTx(8'hC3);
      captureTx(got, sOk);
      sendRx(8'h5A, 1'b1);
    join
    chk(got == 8'hC3 && sOk, "R10 tx during rx", int'(got), 'hC3);
    chk(rxValid == 1'b1 && rxData == 8'h5A, "R10 rx during tx", int'(rxData), 'h5A);
    popRx();
    repeat (bitClks) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule